// File: doc/BRIEF.md
# Trace Byte FIFO with Free-Space Stall Threshold

This block buffers a stream of trace bytes between a producer and a drain port. Its single job beyond storage is to warn the producer early: a register holds a count of free bytes, and when the space left in the buffer falls strictly under that count the block raises a nearly-full flag. Combined with a software stall-enable bit and a capability input from the attached processor, that flag becomes a stall request that holds the processor back before any trace byte is lost.

Software reaches the threshold through a small 32-bit register port. A value above the buffer depth is stored as the depth itself, so a read always shows the setting in force. Two capability bits gate the whole feature: a build-time parameter saying the block supports stalling, and an input saying the processor does. A build without stall support reports that through a zero capability bit, reads the threshold as zero and never raises the flag or the stall.

A push into a completely full buffer is dropped and leaves a sticky overflow flag behind; a pop from an empty buffer does nothing.

Top module: `trace_byte_fifo`

## Requirements
- R1: After reset the buffer is empty, the overflow flag is 0, the threshold holds DEPTH and nearly_full is 0.
- R2: Bytes leave in the order they were accepted; while the buffer is not empty, pop_data shows the oldest byte and a pop removes it at the next rising edge.
- R3: A push while the buffer holds DEPTH bytes is dropped and sets overflow, which stays 1 until reset; a pop while empty leaves the contents unchanged.
- R4: Register address 0 is the threshold in bits [7:0]; bits [31:8] read as 0 and the values written to them have no effect.
- R5: A threshold write above DEPTH stores DEPTH, and a read then returns DEPTH; writes from 0 to DEPTH are stored unchanged.
- R6: nearly_full is 1 exactly when DEPTH minus the byte count is less than the threshold, and takes the new value at the same clock edge that applies a push, pop or threshold write.
- R7: With the threshold at DEPTH, nearly_full is 1 whenever the buffer holds at least one byte.
- R8: stall equals nearly_full AND stall_en AND cpu_stall_ok AND the stall-support parameter; it is 0 for the other three combinations of stall_en and cpu_stall_ok.
- R9: Register address 1 carries the stall-support parameter in bit 23, all other bits 0; when stall support is absent, address 0 reads 0, threshold writes are ignored and nearly_full and stall stay 0.
- R10: A threshold of 0 with stalling enabled never blocks the buffer: bytes still pass in order and the flags are otherwise unspecified.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| push | input | 1 | Write a byte this cycle |
| push_data | input | 8 | Byte to write |
| pop | input | 1 | Remove the oldest byte this cycle |
| pop_data | output | 8 | Oldest byte held |
| empty | output | 1 | Buffer holds no bytes |
| full | output | 1 | Buffer holds DEPTH bytes |
| overflow | output | 1 | Sticky: a push was dropped |
| reg_addr | input | 2 | Register select: 0 threshold, 1 capability |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| stall_en | input | 1 | Software stall enable |
| cpu_stall_ok | input | 1 | Attached processor accepts stalls |
| nearly_full | output | 1 | Free bytes under the threshold |
| stall | output | 1 | Stall request to the processor |

## Verification
The free-space comparison is swept for every threshold from 0 to DEPTH while the buffer fills one byte at a time, so the point where the flag turns on is seen at free space equal to the threshold and one below it. Threshold writes cover values inside the range, the depth itself, just over it, the maximum of the 8-bit field and patterns with reserved bits set, which separates clamping from truncation. A numbered byte sequence followed by an extra push at full and a pop at empty shows ordering, dropping and stickiness, and the stall output is driven through all four capability and enable combinations on a supporting build and a build without support.

// File: rtl/trace_byte_fifo.sv
module trace_byte_fifo #(
  parameter int DEPTH      = 12,
  parameter bit STALL_IMPL = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        push,
  input  logic [7:0]  push_data,
  input  logic        pop,
  output logic [7:0]  pop_data,
  output logic        empty,
  output logic        full,
  output logic        overflow,
  input  logic [1:0]  reg_addr,
  input  logic        reg_wr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        stall_en,
  input  logic        cpu_stall_ok,
  output logic        nearly_full,
  output logic        stall
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [7:0] DEPTH8 = 8'(DEPTH);

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt, cnt_nx;
  logic [7:0]    thr, thr_nx;
  logic          nf_q, ovf_q;
  logic          do_push, do_pop, thr_wr;
  logic          unused_hi;

  assign unused_hi = ^reg_wdata[31:8];

  assign empty    = (cnt == '0);
  assign full     = (cnt == CW'(DEPTH));
  assign do_push  = push && !full;
  assign do_pop   = pop && !empty;
  assign thr_wr   = reg_wr && (reg_addr == 2'd0) && STALL_IMPL;
  assign pop_data = mem[rp];

  always_comb begin
    cnt_nx = cnt;
    if (do_push && !do_pop) cnt_nx = cnt + 1'b1;
    if (do_pop && !do_push) cnt_nx = cnt - 1'b1;
    thr_nx = thr;
    if (thr_wr) thr_nx = (reg_wdata[7:0] > DEPTH8) ? DEPTH8 : reg_wdata[7:0];
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      cnt   <= '0;
      thr   <= DEPTH8;
      nf_q  <= 1'b0;
      ovf_q <= 1'b0;
    end else begin
      if (do_push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      cnt   <= cnt_nx;
      thr   <= thr_nx;
      nf_q  <= STALL_IMPL && ({1'b0, DEPTH8} - 9'(cnt_nx) < {1'b0, thr_nx});
      if (push && full) ovf_q <= 1'b1;
    end
  end

  assign overflow    = ovf_q;
  assign nearly_full = nf_q;
  assign stall       = nf_q && stall_en && cpu_stall_ok && STALL_IMPL;

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = STALL_IMPL ? {24'd0, thr} : 32'd0;
      2'd1:    reg_rdata = {8'd0, STALL_IMPL, 23'd0};
      default: reg_rdata = 32'd0;
    endcase
  end

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH)); // R3
  AST_OVF_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full) |=> overflow); // R3
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow); // R3
  AST_POP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty && !push) |=> empty); // R3
  AST_THR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    thr <= DEPTH8); // R5
  AST_FULL_THR: assert property (@(posedge clk) disable iff (!rst_n)
    (STALL_IMPL && thr == DEPTH8 && !empty) |-> nearly_full); // R7
  AST_STALL_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (nearly_full && stall_en && cpu_stall_ok)); // R8
  AST_NO_SUPPORT: assert property (@(posedge clk) disable iff (!rst_n)
    !STALL_IMPL |-> (!nearly_full && !stall)); // R9

endmodule

// File: tb/trace_byte_fifo_test.sv
`timescale 1ns/1ps
module trace_byte_fifo_test;
  localparam int D = 12;
  logic clk = 1'b0;
  logic rst_n, push, pop, reg_wr, stall_en, cpu_ok;
  logic [7:0] push_data;
  logic [1:0] reg_addr;
  logic [31:0] reg_wdata;
  logic [7:0] pop_data, pop_data_b;
  logic empty, full, overflow, nf, stall;
  logic empty_b, full_b, overflow_b, nf_b, stall_b;
  logic [31:0] rdata, rdata_b;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  trace_byte_fifo #(.DEPTH(D), .STALL_IMPL(1'b1)) uut (
    .clk, .rst_n, .push, .push_data, .pop, .pop_data, .empty, .full, .overflow,
    .reg_addr, .reg_wr, .reg_wdata, .reg_rdata(rdata), .stall_en,
    .cpu_stall_ok(cpu_ok), .nearly_full(nf), .stall);

  trace_byte_fifo #(.DEPTH(8), .STALL_IMPL(1'b0)) uut_nostall (
    .clk, .rst_n, .push, .push_data, .pop, .pop_data(pop_data_b), .empty(empty_b),
    .full(full_b), .overflow(overflow_b), .reg_addr, .reg_wr, .reg_wdata,
    .reg_rdata(rdata_b), .stall_en, .cpu_stall_ok(cpu_ok), .nearly_full(nf_b),
    .stall(stall_b));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic wr_thr(input logic [31:0] v);
    reg_addr = 2'd0; reg_wdata = v; reg_wr = 1'b1;
    tick();
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    reg_addr = a;
    #0.5;
    v = rdata;
  endtask

  task automatic drain();
    for (int i = 0; i < D + 2; i++) begin
      pop = 1'b1;
      tick();
    end
    pop = 1'b0;
  endtask

  task automatic push1(input logic [7:0] b);
    push = 1'b1; push_data = b;
    tick();
    push = 1'b0;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    rst_n = 1'b0; push = 1'b0; pop = 1'b0; reg_wr = 1'b0; stall_en = 1'b0;
    cpu_ok = 1'b0; push_data = '0; reg_addr = '0; reg_wdata = '0;
    tick(); tick();
    rst_n = 1'b1;
    tick();

    // R1 reset state
    chk(empty == 1'b1, "R1 empty", int'(empty), 1);
    chk(overflow == 1'b0, "R1 overflow", int'(overflow), 0);
    chk(nf == 1'b0, "R1 nearly_full", int'(nf), 0);
    rd(2'd0, v);
    chk(v == D, "R1 threshold", int'(v), D);
    rd(2'd1, v);
    chk(v == 32'h0080_0000, "R9 capability word", int'(v), 32'h0080_0000);
    chk(rdata_b == 32'd0, "R9 capability bit clear", int'(rdata_b), 0);

    // R4 R5 clamping and reserved bits
    for (int w = 0; w < 256; w++) begin
      wr_thr(32'(w));
      rd(2'd0, v);
      chk(v == ((w > D) ? D : w), "R5 clamp read-back", int'(v), (w > D) ? D : w);
    end
    wr_thr(32'hFFFF_FF05);
    rd(2'd0, v);
    chk(v == 32'd5, "R4 reserved bits ignored", int'(v), 5);
    wr_thr(32'h1234_56FF);
    rd(2'd0, v);
    chk(v == D, "R4 R5 reserved plus clamp", int'(v), D);

    // R6 R7 R8 threshold sweep while filling
    stall_en = 1'b1; cpu_ok = 1'b1;
    for (int t = 0; t <= D; t++) begin
      drain();
      wr_thr(32'(t));
      if (t != 0) chk(nf == 1'b0, "R6 empty below threshold", int'(nf), 0);
      for (int n = 1; n <= D; n++) begin
        push1(8'(n));
        if (t != 0) begin
          chk(nf == ((D - n) < t), (t == D) ? "R7 nearly_full at depth threshold"
              : "R6 nearly_full vs free", int'(nf), int'((D - n) < t));
          chk(stall == ((D - n) < t), "R8 stall enabled", int'(stall), int'((D - n) < t));
        end
      end
      if (t == 0) begin
        // R10: data still passes intact
        for (int n = 1; n <= D; n++) begin
          chk(pop_data == 8'(n), "R10 data with zero threshold", int'(pop_data), n);
          pop = 1'b1; tick(); pop = 1'b0;
        end
        chk(empty == 1'b1, "R10 drained", int'(empty), 1);
      end
    end

    // R6 threshold write updates flag with buffer unchanged (full now, t=D)
    wr_thr(32'd1);
    chk(nf == 1'b1, "R6 full free 0 below 1", int'(nf), 1);
    pop = 1'b1; tick(); pop = 1'b0;
    chk(nf == 1'b0, "R6 pop to free 1 equals 1", int'(nf), 0);
    push1(8'h00);

    // R8 gating combinations with buffer full
    for (int c = 0; c < 4; c++) begin
      stall_en = c[0]; cpu_ok = c[1];
      #0.5;
      chk(stall == (c == 3), "R8 stall gating", int'(stall), int'(c == 3));
      chk(stall_b == 1'b0, "R9 stall absent", int'(stall_b), 0);
    end
    chk(nf_b == 1'b0, "R9 nearly_full absent", int'(nf_b), 0);
    rd(2'd0, v);
    chk(rdata_b == 32'd0, "R9 threshold reads zero", int'(rdata_b), 0);
    stall_en = 1'b0; cpu_ok = 1'b0;

    // R2 R3 order, drop at full, sticky overflow, pop at empty
    rst_n = 1'b0; tick(); rst_n = 1'b1; tick();
    for (int i = 0; i < D; i++) push1(8'hA0 + 8'(i));
    chk(full == 1'b1, "R3 full", int'(full), 1);
    chk(overflow == 1'b0, "R3 no overflow yet", int'(overflow), 0);
    push1(8'hEE);
    chk(overflow == 1'b1, "R3 overflow set", int'(overflow), 1);
    for (int i = 0; i < D; i++) begin
      chk(pop_data == 8'hA0 + 8'(i), "R2 order", int'(pop_data), 32'hA0 + i);
      pop = 1'b1; tick(); pop = 1'b0;
    end
    chk(empty == 1'b1, "R3 dropped byte absent", int'(empty), 1);
    chk(overflow == 1'b1, "R3 overflow sticky", int'(overflow), 1);
    pop = 1'b1; tick(); pop = 1'b0;
    chk(empty == 1'b1, "R3 pop at empty", int'(empty), 1);
    push1(8'h5A);
    chk(pop_data == 8'h5A, "R3 after empty pop", int'(pop_data), 32'h5A);
    chk(empty == 1'b0, "R2 not empty", int'(empty), 0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule